// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control unit of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory access and write back. The block reads the register specifiers and control bits held in the pipeline registers. From them it chooses the source of each execute-stage ALU operand. It also decides when fetch must hold and when an empty slot must be pushed into the pipe. It has no datapath of its own: the selects and hold/bubble strobes drive muxes and register enables elsewhere.

Operand selection picks the freshest value in flight. A result still in the memory stage wins over one in write back, and a register-file read is used when neither stage matches. A value written back while its consumer is in decode needs no path, because the register file completes its write before its read in the same cycle.

When a load sits in execute and the instruction in decode reads its destination, the block freezes fetch and decode for one cycle and sends an empty slot into execute. The loaded value then reaches the consumer through the write-back forward. A conditional branch in decode is not predicted. Fetch is held and the decode register is loaded with an empty slot for a fixed number of cycles, two by default.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `memRegWrite` is 1, `memRd` is non-zero and `memRd` equals an execute operand's source (`exRs1` for A, `exRs2` for B), that operand's select is 2'b10 (memory-stage result). Each operand is decided independently.
- R2: When the memory stage does not match an operand, and `wbRegWrite` is 1, `wbRd` is non-zero and `wbRd` equals that operand's source, the select is 2'b01 (write-back result).
- R3: When both the memory stage and the write-back stage match an operand, the select is 2'b10: the younger result wins.
- R4: A destination equal to register 0, or one whose write-enable is 0, never causes a forward and never causes a load-use stall.
- R5: With no matching later-stage destination, the select is 2'b00 (register file). The code 2'b11 is never produced.
- R6: Load-use stall. `exMemRead` and `exRegWrite` are both 1, `exRd` is non-zero and `exRd` equals `idRs1` or `idRs2`. In that cycle `pcHold`, `ifIdHold` and `idExBubble` are 1 and `ifIdBubble` is 0. All of these strobes are combinational in the current inputs, so the stall lasts one cycle once the load moves on.
- R7: A non-load instruction in execute whose destination matches a decode source causes no stall; forwarding covers it.
- R8: Branch stall. `idBranch` is 1 with no load-use stall and no branch stall in progress. Then `pcHold` and `ifIdBubble` are 1 in that cycle and in the following BRANCH_BUBBLES-1 cycles, two cycles by default, and 0 afterwards. `ifIdHold` stays 0. Decode-stage inputs are ignored while these bubbles are issued.
- R9: When a load-use stall and a branch in decode occur together, the load-use stall is served first: `ifIdBubble` stays 0. The branch bubbles start in the first cycle in which the load-use condition is gone.
- R10: An active-low reset `rstN` cancels a branch stall in progress. After reset, `ifIdBubble` is 0 until a new branch appears in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idRs1 | input | REG_W | First source register of the instruction in decode |
| idRs2 | input | REG_W | Second source register of the instruction in decode |
| idBranch | input | 1 | Conditional branch in decode |
| exRs1 | input | REG_W | First source register of the instruction in execute |
| exRs2 | input | REG_W | Second source register of the instruction in execute |
| exRd | input | REG_W | Destination of the instruction in execute |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| memRd | input | REG_W | Destination of the instruction in memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | REG_W | Destination of the instruction in write back |
| wbRegWrite | input | 1 | Write-back instruction writes a register |
| fwdSelA | output | 2 | Operand A source: 00 regfile, 01 write back, 10 memory stage |
| fwdSelB | output | 2 | Operand B source, same coding |
| pcHold | output | 1 | Keep the PC unchanged this cycle |
| ifIdHold | output | 1 | Keep the fetch/decode register unchanged |
| ifIdBubble | output | 1 | Load an empty slot into the fetch/decode register |
| idExBubble | output | 1 | Clear the control bits entering execute |

## Verification
A wrong comparison in the operand selection shows up in the same cycle as a wrong code on `fwdSelA` or `fwdSelB`. The bench sweeps every source/destination/enable pairing over a four-register subset. A wrong load-use term shows at once on the three stall strobes. A fault in the branch bubble counter hides until the cycle after a branch: the second bubble goes missing, or a third one appears. The branch sequence therefore checks the strobes on every cycle up to the release, including the cases of priority and reset.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_WB      = 2'b01,
    FWD_MEM     = 2'b10
  } fwd_sel_e;

  // strobes from the compare logic to the stall sequencer
  typedef struct packed {
    logic loadUse;
    logic branchReq;
  } hazard_strobe_t;

endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idBranch,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output fwd_sel_e         fwdSel [2],
  output hazard_strobe_t   strobe
);

  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] exSrc [NUM_OPS];
  logic [REG_W-1:0] idSrc [NUM_OPS];
  logic             memLive;
  logic             wbLive;
  logic             loadLive;
  logic [NUM_OPS-1:0] loadHit;

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;
  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;

  // a destination counts only if it is written and is not register 0
  assign memLive  = memRegWrite && (memRd != '0);
  assign wbLive   = wbRegWrite && (wbRd != '0);
  assign loadLive = exMemRead && exRegWrite && (exRd != '0);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    always_comb begin
      if (memLive && (memRd == exSrc[op]))
        fwdSel[op] = FWD_MEM;
      else if (wbLive && (wbRd == exSrc[op]))
        fwdSel[op] = FWD_WB;
      else
        fwdSel[op] = FWD_REGFILE;
    end
    assign loadHit[op] = loadLive && (exRd == idSrc[op]);
  end

  assign strobe.loadUse   = |loadHit;
  assign strobe.branchReq = idBranch;

endmodule

// File: rtl/hazard_seq.sv
module hazard_seq
  import pipe_hazard_pkg::*;
#(
  parameter int BRANCH_BUBBLES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  hazard_strobe_t strobe,
  output logic           pcHold,
  output logic           ifIdHold,
  output logic           ifIdBubble,
  output logic           idExBubble
);

  localparam int CNT_W = $clog2(BRANCH_BUBBLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BRANCH_BUBBLES - 1);

  logic [CNT_W-1:0] bubbleLeft;
  logic             busy;
  logic             start;

  assign busy  = (bubbleLeft != '0);
  // decode holds an empty slot while busy, so its strobes are ignored then
  assign start = strobe.branchReq && !strobe.loadUse && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bubbleLeft <= '0;
    else if (start)
      bubbleLeft <= RELOAD;
    else if (busy)
      bubbleLeft <= bubbleLeft - 1'b1;
  end

  assign idExBubble = strobe.loadUse && !busy;
  assign ifIdHold   = idExBubble;
  assign ifIdBubble = start || busy;
  assign pcHold     = idExBubble || ifIdBubble;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W          = 5,
  parameter int BRANCH_BUBBLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idBranch,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             pcHold,
  output logic             ifIdHold,
  output logic             ifIdBubble,
  output logic             idExBubble
);

  fwd_sel_e       fwdSel [2];
  hazard_strobe_t strobe;

  hazard_detect #(.REG_W(REG_W)) u_detect (
    .idRs1(idRs1), .idRs2(idRs2), .idBranch(idBranch),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdSel(fwdSel), .strobe(strobe)
  );

  hazard_seq #(.BRANCH_BUBBLES(BRANCH_BUBBLES)) u_seq (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcHold(pcHold), .ifIdHold(ifIdHold),
    .ifIdBubble(ifIdBubble), .idExBubble(idExBubble)
  );

  assign fwdSelA = fwdSel[0];
  assign fwdSelB = fwdSel[1];

endmodule

// File: rtl/pipe_hazard_checker.sv
module pipe_hazard_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] exRs1,
  input logic [REG_W-1:0] exRs2,
  input logic             exMemRead,
  input logic [REG_W-1:0] memRd,
  input logic             memRegWrite,
  input logic [REG_W-1:0] wbRd,
  input logic             wbRegWrite,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB,
  input logic             pcHold,
  input logic             ifIdHold,
  input logic             ifIdBubble,
  input logic             idExBubble
);

  AST_MEM_WINS_A: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd != '0 && memRd == exRs1) |-> fwdSelA == 2'b10); // R3
  AST_MEM_WINS_B: assert property (@(posedge clk) disable iff (!rstN)
    (memRegWrite && memRd != '0 && memRd == exRs2) |-> fwdSelB == 2'b10); // R1
  AST_DEAD_DEST: assert property (@(posedge clk) disable iff (!rstN)
    ((!memRegWrite || memRd == '0) && (!wbRegWrite || wbRd == '0))
      |-> (fwdSelA == 2'b00 && fwdSelB == 2'b00)); // R4
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelA != 2'b11 && fwdSelB != 2'b11); // R5
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |-> (pcHold && ifIdHold && !ifIdBubble)); // R6
  AST_NONLOAD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRead |-> !idExBubble); // R7
  AST_BRANCH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ifIdBubble) |=> ifIdBubble); // R8
  AST_BUBBLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rstN)
    ifIdBubble |-> (pcHold && !ifIdHold)); // R8

endmodule

bind pipe_hazard_ctrl pipe_hazard_checker #(.REG_W(REG_W)) u_checker (
  .clk(clk), .rstN(rstN), .exRs1(exRs1), .exRs2(exRs2),
  .exMemRead(exMemRead), .memRd(memRd), .memRegWrite(memRegWrite),
  .wbRd(wbRd), .wbRegWrite(wbRegWrite), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
  .pcHold(pcHold), .ifIdHold(ifIdHold), .ifIdBubble(ifIdBubble),
  .idExBubble(idExBubble)
);

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

  localparam int REG_W = 5;

  logic clk = 0;
  logic rstN = 0;
  logic [REG_W-1:0] idRs1 = 0, idRs2 = 0, exRs1 = 0, exRs2 = 0, exRd = 0, memRd = 0, wbRd = 0;
  logic idBranch = 0, exRegWrite = 0, exMemRead = 0, memRegWrite = 0, wbRegWrite = 0;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcHold, ifIdHold, ifIdBubble, idExBubble;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(REG_W), .BRANCH_BUBBLES(2)) uut (
    .clk(clk), .rstN(rstN), .idRs1(idRs1), .idRs2(idRs2), .idBranch(idBranch),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exRegWrite(exRegWrite),
    .exMemRead(exMemRead), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .pcHold(pcHold), .ifIdHold(ifIdHold), .ifIdBubble(ifIdBubble),
    .idExBubble(idExBubble)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // strobes packed as {pcHold, ifIdHold, ifIdBubble, idExBubble}
  function automatic int strobes();
    return {28'd0, pcHold, ifIdHold, ifIdBubble, idExBubble};
  endfunction

  function automatic int fwdExp(int src, int m, int mw, int w, int ww);
    if (mw != 0 && m != 0 && m == src) return 2;
    if (ww != 0 && w != 0 && w == src) return 1;
    return 0;
  endfunction

  function automatic string fwdTag(int src, int m, int mw, int w, int ww, int exp);
    if (exp == 2) return (ww != 0 && w != 0 && w == src) ? "R3" : "R1";
    if (exp == 1) return "R2";
    if (m == src || w == src) return "R4";
    return "R5";
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    #1;
    chk("R10", "strobes in reset", strobes(), 0);
    chk("R5", "fwdSelA in reset", fwdSelA, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1;

    // forwarding sweep
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int mw = 0; mw < 2; mw++)
            for (int ww = 0; ww < 2; ww++) begin
              int ea, eb;
              @(negedge clk);
              exRs1 = REG_W'(a); exRs2 = REG_W'(3 - a);
              memRd = REG_W'(m); wbRd = REG_W'(w);
              memRegWrite = mw[0]; wbRegWrite = ww[0];
              #1;
              ea = fwdExp(a, m, mw, w, ww);
              eb = fwdExp(3 - a, m, mw, w, ww);
              chk(fwdTag(a, m, mw, w, ww, ea), "fwdSelA", fwdSelA, ea);
              chk(fwdTag(3 - a, m, mw, w, ww, eb), "fwdSelB", fwdSelB, eb);
            end
    memRegWrite = 0; wbRegWrite = 0;

    // load-use sweep
    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++)
        for (int d = 0; d < 4; d++)
          for (int mr = 0; mr < 2; mr++)
            for (int rw = 0; rw < 2; rw++) begin
              int st;
              string tag;
              @(negedge clk);
              idRs1 = REG_W'(r1); idRs2 = REG_W'(r2); exRd = REG_W'(d);
              exMemRead = mr[0]; exRegWrite = rw[0];
              #1;
              st = (mr != 0 && rw != 0 && d != 0 && (d == r1 || d == r2)) ? 1 : 0;
              if (st != 0) tag = "R6";
              else if (rw != 0 && d != 0 && (d == r1 || d == r2)) tag = "R7";
              else tag = "R4";
              chk(tag, "load-use strobes", strobes(), st != 0 ? 4'b1101 : 0);
            end
    exMemRead = 0; exRegWrite = 0; idRs1 = 0; idRs2 = 0; exRd = 0;

    // branch: two bubbles then release
    @(negedge clk); idBranch = 1; #1;
    chk("R8", "branch cycle 0", strobes(), 4'b1010);
    @(negedge clk); idBranch = 0; idRs1 = 5; exRd = 5; exMemRead = 1; exRegWrite = 1; #1;
    chk("R8", "branch cycle 1 ignores decode", strobes(), 4'b1010);
    @(negedge clk); exMemRead = 0; exRegWrite = 0; #1;
    chk("R8", "branch released", strobes(), 0);

    // load-use first, branch afterwards
    @(negedge clk); idBranch = 1; idRs2 = 7; exRd = 7; exMemRead = 1; exRegWrite = 1; #1;
    chk("R9", "load-use beats branch", strobes(), 4'b1101);
    @(negedge clk); exMemRead = 0; exRegWrite = 0; #1;
    chk("R9", "branch starts after load-use", strobes(), 4'b1010);
    @(negedge clk); idBranch = 0; #1;
    chk("R9", "second bubble", strobes(), 4'b1010);
    @(negedge clk); #1;
    chk("R9", "release", strobes(), 0);

    // reset cancels branch stall
    @(negedge clk); idBranch = 1; #1;
    chk("R10", "branch start before reset", strobes(), 4'b1010);
    @(negedge clk); idBranch = 0; rstN = 0; #1;
    chk("R10", "bubble cancelled by reset", strobes(), 0);
    @(negedge clk); rstN = 1; #1;
    chk("R10", "no bubble after reset", strobes(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule